// File: doc/BRIEF.md
# Indexed Color Palette with Host Register Port

This block turns an 8-bit pixel index stream into three 6-bit color intensities (red, green, blue) through a 256-entry lookup table. The pixel side has its own read port with one cycle of latency. A host writes to that port's storage and reads it back at any time without stalling or disturbing the pixel side.

The host sees four byte-wide registers selected by a 2-bit select. Two of them load a starting index: one for a load sequence and one for a readback sequence. The third is a data register through which each entry moves as three consecutive byte transfers. The fourth reports whether the block is set up for readback or for loading.

A single index and a single component counter serve both directions. The index steps on its own after each complete entry, so a whole palette moves in 768 back-to-back data accesses. Written components wait in holding registers. Storage changes only when the third component of an entry arrives.

Top module: `color_palette`

## Requirements
- R1: While reset is high and after it is released, the pixel outputs are 0 and the block is in load (write) mode with index 0 and the counter at red.
- R2: A host read of select 3 returns 8'h03 in readback mode and 8'h00 in load mode.
- R3: A write to select 0 enters load mode and a write to select 1 enters readback mode. Either one sets the shared index to the written byte and returns the component counter to red.
- R4: Data transfers through select 2 carry one entry as red, then green, then blue. A data write uses only bits 5:0. A data read returns the component in bits 5:0 with bits 7:6 zero.
- R5: After the blue transfer the index advances by one and wraps from 255 to 0, so consecutive entries stream without reloading the index.
- R6: An entry changes only when its blue byte is written. A red or green byte followed by an index load leaves the stored entry unchanged.
- R7: Host read data appears on host_rdata in the cycle after host_rd_en is sampled. Data reads may be issued on every cycle, including the cycle right after a readback index load.
- R8: The pixel outputs show the entry selected by pix_index one clock edge after pix_index is sampled.
- R9: When a blue write commits to the entry the pixel port reads in the same cycle, the pixel outputs show the old entry, and the new entry on the following lookup.
- R10: A data write in readback mode and a data read in load mode are ignored: neither the palette, the index nor the counter changes, and that read returns 8'h00.
- R11: Host reads of select 0 and select 1 return 8'h00. A host read issued in the same cycle as a host write is dropped, and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe |
| host_sel | input | 2 | Register select: 0 load index, 1 readback index, 2 data, 3 state |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| pix_index | input | 8 | Pixel palette index |
| pix_red | output | 6 | Red intensity of looked-up entry |
| pix_green | output | 6 | Green intensity of looked-up entry |
| pix_blue | output | 6 | Blue intensity of looked-up entry |

## Verification
Two functions can fall in the same cycle: a host commit of a full triplet and a pixel lookup of the same entry. The bench sets pix_index to the entry whose blue byte it is writing in that same cycle. It then expects the pre-commit value on the pixel outputs and the new value one lookup later. A second overlap occurs in the cycle after a readback index load or after a blue read. There, the host reads a component while the prefetch of the next entry is still in flight. The bench issues back-to-back data reads across those points and compares each byte with its own palette model.

// File: rtl/pal_pkg.sv
package pal_pkg;

  typedef enum logic [1:0] {
    SEL_LOAD_IDX = 2'd0,
    SEL_READ_IDX = 2'd1,
    SEL_DATA     = 2'd2,
    SEL_STATE    = 2'd3
  } host_sel_e;

  typedef enum logic [1:0] {
    COMP_RED   = 2'd0,
    COMP_GREEN = 2'd1,
    COMP_BLUE  = 2'd2
  } comp_e;

  typedef enum logic {
    MODE_LOAD = 1'b0,
    MODE_READ = 1'b1
  } dir_e;

  localparam int NUM_COMP = 3;

endpackage

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int AW = 8,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] host_addr,
  input  logic          host_we,
  input  logic [DW-1:0] host_wword,
  output logic [DW-1:0] host_q,
  input  logic [AW-1:0] pix_addr,
  output logic [DW-1:0] pix_q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // host port: write plus read-first registered read
  always_ff @(posedge clk) begin
    if (host_we) mem[host_addr] <= host_wword;
    host_q <= mem[host_addr];
  end

  // pixel port: dedicated registered read, old data on same-cycle write
  always_ff @(posedge clk) begin
    if (rst) pix_q <= '0;
    else     pix_q <= mem[pix_addr];
  end

endmodule

// File: rtl/pal_host_ctl.sv
module pal_host_ctl
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  parameter int BUS_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [1:0]               sel,
  input  logic [BUS_W-1:0]         wdata,
  output logic [BUS_W-1:0]         rdata,
  output logic [IDX_W-1:0]         ram_addr,
  output logic                     ram_we,
  output logic [NUM_COMP*COMP_W-1:0] ram_wword,
  input  logic [NUM_COMP*COMP_W-1:0] ram_q
);
  localparam int WORD_W = NUM_COMP * COMP_W;

  dir_e              mode_q, mode_d;
  comp_e             cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              pf_live_q;
  logic [COMP_W-1:0] hold_q [NUM_COMP];

  logic ld_load, ld_read, dwr, drd, rd_hit, step, last, commit, pf_issue;
  logic [WORD_W-1:0] src_word;
  logic [COMP_W-1:0] cur_comp;
  logic [BUS_W-1:0]  rdata_d;

  always_comb begin
    rd_hit   = rd_en && !wr_en;
    ld_load  = wr_en && (host_sel_e'(sel) == SEL_LOAD_IDX);
    ld_read  = wr_en && (host_sel_e'(sel) == SEL_READ_IDX);
    dwr      = wr_en && (host_sel_e'(sel) == SEL_DATA) && (mode_q == MODE_LOAD);
    drd      = rd_hit && (host_sel_e'(sel) == SEL_DATA) && (mode_q == MODE_READ);
    step     = dwr || drd;
    last     = (cnt_q == COMP_BLUE);
    commit   = dwr && last;
    pf_issue = ld_read || (drd && last);
  end

  // next-state of the shared index, counter and direction
  always_comb begin
    idx_d  = idx_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    if (ld_load || ld_read) begin
      idx_d  = wdata[IDX_W-1:0];
      cnt_d  = COMP_RED;
      mode_d = ld_read ? MODE_READ : MODE_LOAD;
    end else if (step) begin
      if (last) begin
        cnt_d = COMP_RED;
        idx_d = idx_q + 1'b1;
      end else begin
        cnt_d = comp_e'(cnt_q + 2'd1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      cnt_q     <= COMP_RED;
      mode_q    <= MODE_LOAD;
      pf_live_q <= 1'b0;
    end else begin
      idx_q     <= idx_d;
      cnt_q     <= cnt_d;
      mode_q    <= mode_d;
      pf_live_q <= pf_issue;
    end
  end

  // one holding register per component: filled by host writes in load
  // mode, or by the prefetched entry in readback mode
  for (genvar c = 0; c < NUM_COMP; c++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst)
        hold_q[c] <= '0;
      else if (pf_live_q)
        hold_q[c] <= ram_q[(NUM_COMP-1-c)*COMP_W +: COMP_W];
      else if (dwr && (cnt_q == comp_e'(c)))
        hold_q[c] <= wdata[COMP_W-1:0];
    end
  end

  // storage port: commit at current index, otherwise prefetch next index
  always_comb begin
    ram_we    = commit;
    ram_addr  = commit ? idx_q : idx_d;
    ram_wword = {hold_q[0], hold_q[1], wdata[COMP_W-1:0]};
  end

  // component returned on a data read; bypass holding while prefetch lands
  always_comb begin
    src_word = pf_live_q ? ram_q : {hold_q[0], hold_q[1], hold_q[2]};
    case (cnt_q)
      COMP_RED:   cur_comp = src_word[2*COMP_W +: COMP_W];
      COMP_GREEN: cur_comp = src_word[COMP_W +: COMP_W];
      default:    cur_comp = src_word[0 +: COMP_W];
    endcase
  end

  always_comb begin
    rdata_d = '0;
    if (rd_hit) begin
      case (host_sel_e'(sel))
        SEL_DATA:  if (mode_q == MODE_READ) rdata_d = {{(BUS_W-COMP_W){1'b0}}, cur_comp};
        SEL_STATE: if (mode_q == MODE_READ) rdata_d = {{(BUS_W-2){1'b0}}, 2'b11};
        default:   rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rdata_d;
  end

  // R5
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> idx_q == IDX_W'($past(idx_q) + 1'b1));

  // R3
  load_red_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_load || ld_read) |=> (cnt_q == COMP_RED) && (idx_q == $past(wdata[IDX_W-1:0])));

  // R2
  state_fmt_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && sel == 2'd3) |=> (rdata[BUS_W-1:2] == '0) && (rdata[1] == rdata[0]));

  // R4
  data_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && sel == 2'd2) |=> rdata[BUS_W-1:COMP_W] == '0);

  // R10
  wr_in_read_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == 2'd2 && mode_q == MODE_READ) |=> $stable(idx_q) && $stable(cnt_q) && !$past(ram_we));

endmodule

// File: rtl/color_palette.sv
module color_palette
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic [1:0]        host_sel,
  input  logic [BUS_W-1:0]  host_wdata,
  output logic [BUS_W-1:0]  host_rdata,
  input  logic [IDX_W-1:0]  pix_index,
  output logic [COMP_W-1:0] pix_red,
  output logic [COMP_W-1:0] pix_green,
  output logic [COMP_W-1:0] pix_blue
);
  localparam int WORD_W = NUM_COMP * COMP_W;

  logic [IDX_W-1:0]  ram_addr;
  logic              ram_we;
  logic [WORD_W-1:0] ram_wword, ram_q, pix_q;

  pal_host_ctl #(.IDX_W(IDX_W), .COMP_W(COMP_W), .BUS_W(BUS_W)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (host_wr_en),
    .rd_en    (host_rd_en),
    .sel      (host_sel),
    .wdata    (host_wdata),
    .rdata    (host_rdata),
    .ram_addr (ram_addr),
    .ram_we   (ram_we),
    .ram_wword(ram_wword),
    .ram_q    (ram_q)
  );

  pal_ram #(.AW(IDX_W), .DW(WORD_W)) u_ram (
    .clk       (clk),
    .rst       (rst),
    .host_addr (ram_addr),
    .host_we   (ram_we),
    .host_wword(ram_wword),
    .host_q    (ram_q),
    .pix_addr  (pix_index),
    .pix_q     (pix_q)
  );

  assign pix_red   = pix_q[2*COMP_W +: COMP_W];
  assign pix_green = pix_q[COMP_W +: COMP_W];
  assign pix_blue  = pix_q[0 +: COMP_W];

  // R1
  pix_rst_chk: assert property (@(posedge clk)
    $past(rst) |-> (pix_red == '0 && pix_green == '0 && pix_blue == '0));

endmodule

// File: tb/color_palette_test.sv
`timescale 1ns/1ps
module color_palette_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr_en = 1'b0, host_rd_en = 1'b0;
  logic [1:0] host_sel = 2'd0;
  logic [7:0] host_wdata = 8'd0, host_rdata;
  logic [7:0] pix_index = 8'd0;
  logic [5:0] pix_red, pix_green, pix_blue;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [17:0] m_mem [256];
  logic        m_rd;
  logic [7:0]  m_idx;
  int          m_cnt;
  logic [5:0]  m_h [3];

  always #2 clk = ~clk;

  color_palette uut (.*);

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic logic [5:0] comp_of(input logic [17:0] w, input int c);
    return (c == 0) ? w[17:12] : (c == 1) ? w[11:6] : w[5:0];
  endfunction

  task automatic host_wr(input logic [1:0] s, input logic [7:0] d);
    host_wr_en = 1'b1; host_sel = s; host_wdata = d;
    @(posedge clk); @(negedge clk);
    host_wr_en = 1'b0;
    if (s == 2'd0) begin m_rd = 1'b0; m_idx = d; m_cnt = 0; end
    else if (s == 2'd1) begin m_rd = 1'b1; m_idx = d; m_cnt = 0; end
    else if (s == 2'd2 && !m_rd) begin
      m_h[m_cnt] = d[5:0];
      if (m_cnt == 2) begin
        m_mem[m_idx] = {m_h[0], m_h[1], d[5:0]};
        m_idx++; m_cnt = 0;
      end else m_cnt++;
    end
  endtask

  task automatic host_rd(input logic [1:0] s, input string req);
    logic [7:0] exp;
    exp = 8'd0;
    if (s == 2'd3) exp = m_rd ? 8'h03 : 8'h00;
    else if (s == 2'd2 && m_rd) exp = {2'b00, comp_of(m_mem[m_idx], m_cnt)};
    host_rd_en = 1'b1; host_sel = s;
    @(posedge clk); @(negedge clk);
    host_rd_en = 1'b0;
    chk(req, host_rdata, exp);
    if (s == 2'd2 && m_rd) begin
      if (m_cnt == 2) begin m_idx++; m_cnt = 0; end else m_cnt++;
    end
  endtask

  task automatic pix_chk(input logic [7:0] i, input string req);
    pix_index = i;
    @(posedge clk); @(negedge clk);
    chk(req, {pix_red, pix_green, pix_blue}, m_mem[i]);
  endtask

  task automatic wr_entry(input logic [7:0] i, input logic [17:0] w);
    host_wr(2'd0, i);
    host_wr(2'd2, {2'b10, w[17:12]});
    host_wr(2'd2, {2'b01, w[11:6]});
    host_wr(2'd2, {2'b11, w[5:0]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [17:0] old_w, new_w;
    void'($urandom(32'd1234));
    m_rd = 1'b0; m_idx = 8'd0; m_cnt = 0;
    repeat (3) @(negedge clk);
    chk("R1 pixel zero in reset", {pix_red, pix_green, pix_blue}, 0);
    rst = 1'b0;
    @(negedge clk);
    host_rd(2'd3, "R1 load mode after reset");

    // R5 stream whole palette from index 0 with no reload
    host_wr(2'd0, 8'd0);
    for (int k = 0; k < 768; k++) host_wr(2'd2, 8'($urandom));
    host_rd(2'd3, "R2 state in load mode");
    host_rd(2'd2, "R10 data read in load mode returns zero");

    // R7 back-to-back readback of all entries, then wrap R5
    host_wr(2'd1, 8'd0);
    host_rd(2'd3, "R2 state in readback mode");
    host_wr(2'd1, 8'd0);
    for (int k = 0; k < 771; k++) host_rd(2'd2, "R4 R7 streamed readback");
    chk("R5 index wrapped after 256 entries", m_idx, 8'd1);

    // R5 wrap on load
    host_wr(2'd0, 8'd255);
    for (int k = 0; k < 6; k++) host_wr(2'd2, 8'($urandom));
    pix_chk(8'd255, "R5 entry 255 loaded");
    pix_chk(8'd0, "R5 wrap to entry 0 loaded");

    // R6 partial triplet then reload
    old_w = m_mem[8'd40];
    host_wr(2'd0, 8'd40);
    host_wr(2'd2, 8'h15);
    host_wr(2'd2, 8'h2a);
    host_wr(2'd1, 8'd40);
    chk("R6 partial leaves model", m_mem[8'd40], old_w);
    for (int k = 0; k < 3; k++) host_rd(2'd2, "R6 partial triplet ignored");
    pix_chk(8'd40, "R6 pixel sees unchanged entry");

    // R10 data write in readback mode ignored
    host_wr(2'd1, 8'd41);
    host_rd(2'd2, "R10 red before ignored write");
    host_wr(2'd2, 8'h3f);
    host_rd(2'd2, "R10 green after ignored write");
    host_rd(2'd2, "R10 blue after ignored write");
    // R10 data read in load mode does not advance
    host_wr(2'd0, 8'd42);
    host_wr(2'd2, 8'h01);
    host_rd(2'd2, "R10 read in load mode zero");
    host_wr(2'd2, 8'h02);
    host_wr(2'd2, 8'h03);
    pix_chk(8'd42, "R10 entry loaded in order");
    chk("R4 order red green blue", m_mem[8'd42], {6'h01, 6'h02, 6'h03});

    // R11 index registers read as zero; simultaneous read dropped
    host_rd(2'd0, "R11 load index reads zero");
    host_rd(2'd1, "R11 readback index reads zero");
    host_rd_en = 1'b1;
    host_wr(2'd1, 8'd42);
    host_rd_en = 1'b0;
    chk("R11 read with write dropped", host_rdata, 0);
    host_rd(2'd2, "R11 write took effect");

    // R8 pixel lookups
    for (int k = 0; k < 40; k++) pix_chk(8'($urandom), "R8 pixel lookup");

    // R9 same-cycle commit and pixel read
    for (int k = 0; k < 4; k++) begin
      logic [7:0] e;
      e = 8'($urandom);
      old_w = m_mem[e];
      new_w = 18'($urandom);
      host_wr(2'd0, e);
      host_wr(2'd2, {2'b00, new_w[17:12]});
      host_wr(2'd2, {2'b00, new_w[11:6]});
      pix_index = e;
      host_wr(2'd2, {2'b00, new_w[5:0]});
      chk("R9 pixel shows old entry", {pix_red, pix_green, pix_blue}, old_w);
      @(posedge clk); @(negedge clk);
      chk("R9 pixel shows new entry", {pix_red, pix_green, pix_blue}, new_w);
    end

    // random mix
    for (int k = 0; k < 2000; k++) begin
      int op;
      op = int'($urandom % 10);
      if (op == 0) host_wr(2'd0, 8'($urandom));
      else if (op == 1) host_wr(2'd1, 8'($urandom));
      else if (op < 5) host_wr(2'd2, 8'($urandom));
      else if (op < 8) host_rd(2'd2, "R3 R4 random data read");
      else if (op == 8) host_rd(2'd3, "R2 random state read");
      else pix_chk(8'($urandom), "R8 random pixel lookup");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule